// File: doc/BRIEF.md
# Port Interrupt Status and Enable Unit

This unit gathers eleven single-cycle event pulses from one storage port into a sticky status register. It holds a per-source enable mask and raises one interrupt line whenever an enabled source is pending. Software reads one word that carries two copies of the eleven events. The low half is gated by the enable mask and the high half is unmasked. The mask has its own set and clear offsets, so one source can be changed without a read-modify-write. Both mask writes also load a two-bit steering code. The steering code is driven out of the unit for a neighbouring router and is read back together with the mask.

A mode input selects how pending bits leave the register. With write-one-to-clear selected, software clears a bit by writing 1 to its position in either half of the status word. With it deselected, status writes are ignored. In that mode the completion bit drops by itself once the command engine reports that no slot is pending. The unit has no state machine. The house FSM layout does not apply, so only its naming and reset conventions are kept. There is one register process per submodule, and the read path is combinational.

Top module: `port_irq_unit`

## Requirements
- R1: After reset the status register, the enable mask and the steering code are all zero, and `irq_out` is low.
- R2: An event pulse on `evt_pulse[i]` sets status bit i at the next rising edge, and the bit stays set until it is cleared. The index assignment is: 0 command complete, 1 command error, 2 port-ready change, 3 power change, 4 PHY-ready change, 5 wake received, 6 unknown frame, 7 device exchanged, 8 decode-error threshold, 9 CRC-error threshold, 10 handshake-error threshold.
- R3: A read at offset 0x0 returns the raw status in bits 26:16 and the status ANDed with the enable mask in bits 10:0. All other bits read zero.
- R4: A write at offset 0x8 sets every enable bit whose data bit 10:0 is 1. A write at offset 0xC clears every enable bit whose data bit is 1. Enable bits whose data bit is 0 are unchanged.
- R5: A read at offset 0x8 returns the steering code in bits 31:30 and the enable mask in bits 10:0, with all other bits zero. Reads at 0xC and at any other offset return zero.
- R6: Any write at offset 0x8 or 0xC loads the steering code from data bits 31:30, and `irq_steer` shows it from the following cycle.
- R7: With `w1c_mode` high, a write at offset 0x0 clears status bit i when data bit i or data bit 16+i is 1.
- R8: When an event pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: With `w1c_mode` low, writes at offset 0x0 leave every status bit unchanged.
- R10: With `w1c_mode` low, status bit 0 clears at any edge where `slot_pending` is low and no completion pulse arrives. With `w1c_mode` high, `slot_pending` has no effect.
- R11: `irq_out` is high exactly when at least one masked status bit (read bits 10:0) is 1. It follows the registered state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 11 | One-cycle event pulses, indexed as in R2 |
| slot_pending | input | 1 | High while any command slot is still outstanding |
| w1c_mode | input | 1 | 1: write-one-to-clear; 0: hardware acknowledgement |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq_out | output | 1 | Port interrupt request |
| irq_steer | output | 2 | Steering code from the last mask write |

## Verification
The bench builds the unit with its default parameters: eleven sources, the raw copy starting at bit 16 and a 32-bit data word. These values make every field position in R3 and R5 a fixed, checkable constant. They also put the steering code at the top two bits, clear of both status halves. A behavioural model runs every clock and is read back through all three offsets. Directed cases cover clearing through each half, event and clear collisions, ignored writes when write-one-to-clear is off, and completion auto-clear with `slot_pending` both high and low. A long stretch of random traffic then mixes mode changes, mask writes and unused offsets.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    // Register byte offsets; the clear-mask offset sits 4 above the set-mask offset
    localparam logic [3:0] OFF_STATUS = 4'h0;
    localparam logic [3:0] OFF_EN_SET = 4'h8;
    localparam logic [3:0] OFF_EN_CLR = 4'hC;

    // Event source positions
    typedef enum int {
        EV_CMPL     = 0,
        EV_ERR      = 1,
        EV_PRDY     = 2,
        EV_PWR      = 3,
        EV_PHYRDY   = 4,
        EV_WAKE     = 5,
        EV_UNKFRAME = 6,
        EV_XCHG     = 7,
        EV_DECODE   = 8,
        EV_CRC      = 9,
        EV_HSHK     = 10
    } evt_idx_e;

    localparam int STEER_W = 2;
endpackage

// File: rtl/pirq_status.sv
module pirq_status #(
    parameter int NUM_EVT = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] clr_i,
    input  logic               w1c_mode_i,
    input  logic               slot_pending_i,
    output logic [NUM_EVT-1:0] status_o
);
    import pirq_pkg::*;

    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] status_d;
    logic [NUM_EVT-1:0] drop;

    // Per-bit clear request; the completion bit also has the hardware path
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        if (i == EV_CMPL) begin : g_cmpl
            assign drop[i] = w1c_mode_i ? clr_i[i] : ~slot_pending_i;
        end else begin : g_other
            assign drop[i] = w1c_mode_i & clr_i[i];
        end
    end

    always_comb begin
        // An arriving event outranks a clear of the same bit
        status_d = (status_q & ~drop) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

    p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_mode_i && clr_i != '0) |=> ((status_q & $past(clr_i & ~evt_i)) == '0));

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & evt_i) != '0) |=> ((status_q & $past(clr_i & evt_i)) != '0));

    p_hold_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!w1c_mode_i) |=> ((status_q[NUM_EVT-1:1] & $past(status_q[NUM_EVT-1:1]))
                           == $past(status_q[NUM_EVT-1:1])));

    p_cmpl_autoclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!w1c_mode_i && !slot_pending_i && !evt_i[EV_CMPL]) |=> !status_q[EV_CMPL]);
endmodule

// File: rtl/pirq_enable.sv
module pirq_enable #(
    parameter int NUM_EVT = 11,
    parameter int STEER_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we_i,
    input  logic               clr_we_i,
    input  logic [NUM_EVT-1:0] bits_i,
    input  logic [STEER_W-1:0] steer_i,
    output logic [NUM_EVT-1:0] en_o,
    output logic [STEER_W-1:0] steer_o
);
    logic [NUM_EVT-1:0] en_q;
    logic [STEER_W-1:0] steer_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            steer_q <= '0;
        end else begin
            if (set_we_i) begin
                en_q <= en_q | bits_i;
            end else if (clr_we_i) begin
                en_q <= en_q & ~bits_i;
            end
            if (set_we_i || clr_we_i) begin
                steer_q <= steer_i;
            end
        end
    end

    assign en_o    = en_q;
    assign steer_o = steer_q;

    p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((en_q & $past(bits_i)) == $past(bits_i)));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !set_we_i) |=> ((en_q & $past(bits_i)) == '0));

    p_steer_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i || clr_we_i) |=> (steer_q == $past(steer_i)));

    p_steer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we_i && !clr_we_i) |=> $stable(steer_q));
endmodule

// File: rtl/pirq_regif.sv
module pirq_regif #(
    parameter int NUM_EVT = 11,
    parameter int RAW_LSB = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int STEER_W = 2
) (
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [NUM_EVT-1:0] status_i,
    input  logic [NUM_EVT-1:0] en_i,
    input  logic [STEER_W-1:0] steer_i,
    output logic [NUM_EVT-1:0] clr_o,
    output logic               en_set_we_o,
    output logic               en_clr_we_o,
    output logic [NUM_EVT-1:0] wbits_o,
    output logic [STEER_W-1:0] wsteer_o,
    output logic [DATA_W-1:0]  rd_data_o
);
    import pirq_pkg::*;

    localparam int STEER_LSB = DATA_W - STEER_W;

    logic status_we;
    logic unused_wdata;

    assign status_we   = wr_en_i && (wr_addr_i == ADDR_W'(OFF_STATUS));
    assign en_set_we_o = wr_en_i && (wr_addr_i == ADDR_W'(OFF_EN_SET));
    assign en_clr_we_o = wr_en_i && (wr_addr_i == ADDR_W'(OFF_EN_CLR));
    assign wbits_o     = wr_data_i[NUM_EVT-1:0];
    assign wsteer_o    = wr_data_i[STEER_LSB +: STEER_W];
    assign unused_wdata = ^wr_data_i;

    // Either half of the status word clears the same bit
    assign clr_o = status_we ? (wr_data_i[NUM_EVT-1:0] | wr_data_i[RAW_LSB +: NUM_EVT])
                             : '0;

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_W'(OFF_STATUS): begin
                rd_data_o[NUM_EVT-1:0]       = status_i & en_i;
                rd_data_o[RAW_LSB +: NUM_EVT] = status_i;
            end
            ADDR_W'(OFF_EN_SET): begin
                rd_data_o[NUM_EVT-1:0]         = en_i;
                rd_data_o[STEER_LSB +: STEER_W] = steer_i;
            end
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit #(
    parameter int NUM_EVT = 11,
    parameter int RAW_LSB = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               slot_pending,
    input  logic               w1c_mode,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_out,
    output logic [1:0]         irq_steer
);
    import pirq_pkg::*;

    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] clr;
    logic [NUM_EVT-1:0] wbits;
    logic [STEER_W-1:0] wsteer;
    logic [STEER_W-1:0] steer_q;
    logic               en_set_we;
    logic               en_clr_we;

    pirq_regif #(
        .NUM_EVT(NUM_EVT), .RAW_LSB(RAW_LSB), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .STEER_W(STEER_W)
    ) u_regif (
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .status_i    (status_q),
        .en_i        (en_q),
        .steer_i     (steer_q),
        .clr_o       (clr),
        .en_set_we_o (en_set_we),
        .en_clr_we_o (en_clr_we),
        .wbits_o     (wbits),
        .wsteer_o    (wsteer),
        .rd_data_o   (rd_data)
    );

    pirq_status #(.NUM_EVT(NUM_EVT)) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_i          (evt_pulse),
        .clr_i          (clr),
        .w1c_mode_i     (w1c_mode),
        .slot_pending_i (slot_pending),
        .status_o       (status_q)
    );

    pirq_enable #(.NUM_EVT(NUM_EVT), .STEER_W(STEER_W)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (en_set_we),
        .clr_we_i (en_clr_we),
        .bits_i   (wbits),
        .steer_i  (wsteer),
        .en_o     (en_q),
        .steer_o  (steer_q)
    );

    assign irq_out   = |(status_q & en_q);
    assign irq_steer = steer_q;

    p_irq_needs_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((status_q != '0) && (en_q != '0)));

    p_irq_from_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & en_q) != '0 && !en_clr_we) |=> irq_out);
endmodule

// File: tb/port_irq_unit_tb.sv
`timescale 1ns/10ps
module port_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_pulse = '0;
    logic        slot_pending = 1'b1;
    logic        w1c_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_out;
    logic [1:0]  irq_steer;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state
    bit [10:0] m_stat = '0;
    bit [10:0] m_en = '0;
    bit [1:0]  m_steer = '0;

    always #2.5 clk = ~clk;

    port_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .slot_pending(slot_pending),
        .w1c_mode(w1c_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out), .irq_steer(irq_steer)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    function automatic bit [31:0] m_status_word();
        bit [31:0] w = '0;
        w[10:0]  = m_stat & m_en;
        w[26:16] = m_stat;
        return w;
    endfunction

    // Compare every observable against the model
    task automatic compare_all();
        logic [31:0] v;
        rd(4'h0, v); chk("R3 status word", v, m_status_word());
        rd(4'h8, v); chk("R5 enable read", v, {m_steer, 19'd0, m_en});
        rd(4'hC, v); chk("R5 clear-offset read", v, 32'd0);
        rd(4'h4, v); chk("R5 unused read", v, 32'd0);
        chk("R11 irq", {31'd0, irq_out}, {31'd0, |(m_stat & m_en)});
        chk("R6 steer", {30'd0, irq_steer}, {30'd0, m_steer});
    endtask

    // One clock: drive at negedge, update the model after the edge, compare
    task automatic step(input bit [10:0] ev, input bit we, input bit [3:0] a, input bit [31:0] d);
        bit [10:0] nxt;
        @(negedge clk);
        evt_pulse = ev; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        #0.5;
        nxt = m_stat;
        if (w1c_mode && we && a == 4'h0) nxt = nxt & ~(d[10:0] | d[26:16]);
        if (!w1c_mode && !slot_pending) nxt[0] = 1'b0;
        nxt = nxt | ev;
        m_stat = nxt;
        if (we && a == 4'h8) begin m_en = m_en | d[10:0]; m_steer = d[31:30]; end
        if (we && a == 4'hC) begin m_en = m_en & ~d[10:0]; m_steer = d[31:30]; end
        evt_pulse = '0; wr_en = 1'b0;
        compare_all();
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        rd(4'h0, v); chk("R1 status after reset", v, 32'd0);
        rd(4'h8, v); chk("R1 enable after reset", v, 32'd0);
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1 steer after reset", {30'd0, irq_steer}, 32'd0);

        w1c_mode = 1'b1; slot_pending = 1'b1;
        step(11'h002, 0, 4'h0, 0);
        rd(4'h0, v); chk("R2 error event raw only", v, 32'h0002_0000);
        chk("R11 irq low when masked", {31'd0, irq_out}, 32'd0);

        step(0, 1, 4'h8, 32'hC000_0003);
        rd(4'h8, v); chk("R4 enable set", v, 32'hC000_0003);
        rd(4'h0, v); chk("R3 masked half", v, 32'h0002_0002);
        chk("R11 irq high", {31'd0, irq_out}, 32'd1);

        step(0, 1, 4'hC, 32'h4000_0002);
        rd(4'h8, v); chk("R4 enable clear", v, 32'h4000_0001);
        chk("R6 steer load on clear", {30'd0, irq_steer}, 32'd1);
        chk("R11 irq low after mask clear", {31'd0, irq_out}, 32'd0);

        step(11'h401, 0, 4'h0, 0);
        rd(4'h0, v); chk("R2 complete and handshake", v, 32'h0403_0001);

        step(0, 1, 4'h0, 32'h0400_0000);
        rd(4'h0, v); chk("R7 clear via raw half", v, 32'h0003_0001);
        step(0, 1, 4'h0, 32'h0000_0001);
        rd(4'h0, v); chk("R7 clear via masked half", v, 32'h0002_0000);

        step(11'h002, 1, 4'h0, 32'h0000_0002);
        rd(4'h0, v); chk("R8 event beats clear", v, 32'h0002_0000);
        step(0, 1, 4'h0, 32'h0000_0002);
        rd(4'h0, v); chk("R7 clear after collision", v, 32'd0);

        @(negedge clk); w1c_mode = 1'b0; slot_pending = 1'b1;
        step(11'h021, 0, 4'h0, 0);
        step(0, 1, 4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R9 status write ignored", v, 32'h0021_0001);

        @(negedge clk); slot_pending = 1'b0;
        step(0, 0, 4'h0, 0);
        rd(4'h0, v); chk("R10 completion auto-clear", v, 32'h0020_0000);
        step(11'h001, 0, 4'h0, 0);
        rd(4'h0, v); chk("R8 R10 completion beats auto-clear", v, 32'h0021_0001);
        step(0, 0, 4'h0, 0);
        rd(4'h0, v); chk("R10 clears next idle edge", v, 32'h0020_0000);

        @(negedge clk); w1c_mode = 1'b1;
        step(11'h001, 0, 4'h0, 0);
        step(0, 0, 4'h0, 0);
        rd(4'h0, v); chk("R10 no auto-clear in w1c mode", v, 32'h0021_0001);

        for (int n = 0; n < 600; n++) begin
            bit [3:0] a;
            bit [31:0] d;
            case ($urandom % 4)
                0: a = 4'h0;
                1: a = 4'h8;
                2: a = 4'hC;
                default: a = 4'h4;
            endcase
            d = $urandom;
            if (n % 37 == 0) begin
                @(negedge clk);
                w1c_mode = $urandom % 2;
                slot_pending = $urandom % 2;
            end
            step(11'($urandom & $urandom & 32'h7FF), ($urandom % 3) == 0, a, d);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 5);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule